// File: doc/BRIEF.md
# Effective Address Generator

This unit turns the addressing fields of an already decoded instruction into the value that the operand access stage needs. That value is either an effective memory address or, for the two non-memory modes, the operand itself. A one-cycle `start` strobe presents four things together: a 3-bit mode, a short address/offset field, a register-select field with the matching register-file read data, and the incremented program counter and index register. One cycle later the unit raises `valid` and holds its results until the next accepted request.

Eight modes are selected by the mode field. A separate index-enable bit picks indexed addressing and overrides the mode field. The pointer modes with automatic post-adjust raise a register write request together with `valid`. This request carries the pointer plus or minus one. The memory-indirect mode performs one extra memory read through a request/acknowledge handshake. The word returned by that read becomes the effective address. While this read is outstanding, new start strobes are ignored. All address sums wrap modulo 2^ADDR_W.

Top module: `ea_gen`

## Requirements
- R1: During and after reset, with no start, `valid`, `memRdReq`, `regWrEn` and `operandHit` are 0 and `effAddr` is 0.
- R2: Direct mode (modeSel=101, indexEn=0): `valid` is 1 in the cycle after the start edge and `effAddr` equals the address field zero-extended.
- R3: Immediate mode (000): `operandHit`=1, `operandVal` is the address field zero-extended, and `effAddr`=0.
- R4: Register mode (001): `operandHit`=1, `operandVal` equals `regRdData`, and `effAddr`=0.
- R5: Register-indirect mode (010): `effAddr` equals `regRdData`, `operandHit`=0, and no register write is requested.
- R6: Auto-increment mode (011): `effAddr` equals `regRdData`. `regWrEn` pulses with `valid`, `regWrSel` equals `regSel`, and `regWrData` is `regRdData`+1 modulo 2^ADDR_W.
- R7: Auto-decrement mode (100) behaves as R6, except that `regWrData` is `regRdData`-1 modulo 2^ADDR_W.
- R8: Relative mode (111): `effAddr` is `pcNext` plus the address field sign-extended from FIELD_W bits, modulo 2^ADDR_W. For example, pcNext 826 with field 24 gives 850.
- R9: When indexEn=1, `effAddr` is `indexReg` plus the address field zero-extended, modulo 2^ADDR_W, whatever the value of modeSel.
- R10: Indirect mode (110): in the cycle after start, `memRdReq`=1 and `memRdAddr` equals the field zero-extended. Both stay unchanged until an edge with `memRdAck`=1. In the cycle after that edge, `valid`=1, `memRdReq`=0 and `effAddr` equals the `memRdData` captured at the acknowledge edge.
- R11: A start strobe while an indirect read is outstanding is ignored: `memRdAddr` is unchanged and no extra `valid` pulse follows.
- R12: `regWrEn` is 1 only in a cycle where `valid` is 1 and the request used mode 011 or 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; the inputs below are sampled with it |
| modeSel | input | 3 | Addressing mode code |
| indexEn | input | 1 | Selects indexed addressing, overriding modeSel |
| addrField | input | FIELD_W (8) | Address or offset field of the instruction |
| regSel | input | REG_SEL_W (3) | Register selected by the instruction |
| regRdData | input | ADDR_W (16) | Register-file read data for regSel |
| pcNext | input | ADDR_W (16) | Program counter already past the instruction |
| indexReg | input | ADDR_W (16) | Index register value |
| memRdReq | output | 1 | Indirect pointer read request |
| memRdAddr | output | ADDR_W (16) | Indirect pointer read address |
| memRdAck | input | 1 | Read acknowledge; memRdData valid with it |
| memRdData | input | ADDR_W (16) | Read data |
| valid | output | 1 | Result strobe, one cycle |
| effAddr | output | ADDR_W (16) | Effective address |
| operandHit | output | 1 | Result is an operand, not an address |
| operandVal | output | ADDR_W (16) | Immediate or register operand |
| regWrEn | output | 1 | Pointer write-back request |
| regWrSel | output | REG_SEL_W (3) | Pointer register to update |
| regWrData | output | ADDR_W (16) | Adjusted pointer value |

## Verification
Every mode except the indirect one produces its result exactly one edge after the start edge. The bench applies each table vector on a falling edge and samples all outputs on the next falling edge. It then samples once more to confirm that `valid` has dropped. For the indirect mode, the read request is due one edge after start. The result is due one edge after the acknowledge edge. The bench checks the request at each falling edge while it holds off the acknowledge, including the cycle with an ignored start. It then checks `valid` and `effAddr` on the falling edge after the acknowledge, and checks the absence of a second pulse on the falling edge after that.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    MODE_IMM    = 3'b000,
    MODE_REG    = 3'b001,
    MODE_REGIND = 3'b010,
    MODE_AINC   = 3'b011,
    MODE_ADEC   = 3'b100,
    MODE_DIR    = 3'b101,
    MODE_IND    = 3'b110,
    MODE_REL    = 3'b111
  } eaMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNow;  // compute and register a one-step result
    logic armRead;  // latch the pointer read address
    logic takeMem;  // capture the returned pointer as the address
  } eaStrobe_t;
endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [2:0] modeSel,
  input  logic      indexEn,
  input  logic      memRdAck,
  output eaStrobe_t strobes,
  output logic      validOut,
  output logic      memRdReq
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_t;
  ctlState_t state;

  logic isIndirect;
  logic accept;
  assign isIndirect = (modeSel == MODE_IND) && !indexEn;
  assign accept     = start && (state == ST_IDLE);

  always_comb begin
    strobes.takeNow = accept && !isIndirect;
    strobes.armRead = accept && isIndirect;
    strobes.takeMem = (state == ST_WAIT) && memRdAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      validOut <= 1'b0;
    end else begin
      validOut <= strobes.takeNow || strobes.takeMem;
      case (state)
        ST_IDLE: if (strobes.armRead) state <= ST_WAIT;
        default: if (memRdAck)        state <= ST_IDLE;
      endcase
    end
  end

  assign memRdReq = (state == ST_WAIT);

  // R2
  one_step_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !memRdReq && !isIndirect) |=> validOut);

  // R10
  read_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> (memRdReq && !validOut));

  // R10
  ack_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck) |=> (validOut && !memRdReq));
endmodule

// File: rtl/ea_gen_dp.sv
module ea_gen_dp
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIELD_W   = 8,
  parameter int REG_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eaStrobe_t            strobes,
  input  logic [2:0]           modeSel,
  input  logic                 indexEn,
  input  logic [FIELD_W-1:0]   addrField,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [ADDR_W-1:0]    regRdData,
  input  logic [ADDR_W-1:0]    pcNext,
  input  logic [ADDR_W-1:0]    indexReg,
  input  logic [ADDR_W-1:0]    memRdData,
  output logic [ADDR_W-1:0]    memRdAddr,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 operandHit,
  output logic [ADDR_W-1:0]    operandVal,
  output logic                 regWrEn,
  output logic [REG_SEL_W-1:0] regWrSel,
  output logic [ADDR_W-1:0]    regWrData
);
  localparam int EXT_W = ADDR_W - FIELD_W;

  logic [ADDR_W-1:0] fieldZero, fieldSign;
  logic [ADDR_W-1:0] nextAddr, nextOperand, nextPtr;
  logic              nextHit, nextWr;

  assign fieldZero = {{EXT_W{1'b0}}, addrField};
  assign fieldSign = {{EXT_W{addrField[FIELD_W-1]}}, addrField};

  always_comb begin
    nextAddr    = '0;
    nextOperand = '0;
    nextHit     = 1'b0;
    nextWr      = 1'b0;
    nextPtr     = regRdData;
    if (indexEn) begin
      nextAddr = indexReg + fieldZero;
    end else begin
      case (modeSel)
        MODE_IMM:    begin nextHit = 1'b1; nextOperand = fieldZero; end
        MODE_REG:    begin nextHit = 1'b1; nextOperand = regRdData; end
        MODE_REGIND: nextAddr = regRdData;
        MODE_AINC:   begin nextAddr = regRdData; nextWr = 1'b1; nextPtr = regRdData + ADDR_W'(1); end
        MODE_ADEC:   begin nextAddr = regRdData; nextWr = 1'b1; nextPtr = regRdData - ADDR_W'(1); end
        MODE_DIR:    nextAddr = fieldZero;
        MODE_REL:    nextAddr = pcNext + fieldSign;
        default:     nextAddr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr    <= '0;
      operandHit <= 1'b0;
      operandVal <= '0;
      regWrEn    <= 1'b0;
      regWrSel   <= '0;
      regWrData  <= '0;
      memRdAddr  <= '0;
    end else begin
      regWrEn <= strobes.takeNow && nextWr;
      if (strobes.takeNow) begin
        effAddr    <= nextAddr;
        operandHit <= nextHit;
        operandVal <= nextOperand;
        regWrSel   <= regSel;
        regWrData  <= nextPtr;
      end
      if (strobes.armRead) memRdAddr <= fieldZero;
      if (strobes.takeMem) begin
        effAddr    <= memRdData;
        operandHit <= 1'b0;
      end
    end
  end

  // R12
  wr_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(strobes.takeNow));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIELD_W   = 8,
  parameter int REG_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [2:0]           modeSel,
  input  logic                 indexEn,
  input  logic [FIELD_W-1:0]   addrField,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [ADDR_W-1:0]    regRdData,
  input  logic [ADDR_W-1:0]    pcNext,
  input  logic [ADDR_W-1:0]    indexReg,
  output logic                 memRdReq,
  output logic [ADDR_W-1:0]    memRdAddr,
  input  logic                 memRdAck,
  input  logic [ADDR_W-1:0]    memRdData,
  output logic                 valid,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 operandHit,
  output logic [ADDR_W-1:0]    operandVal,
  output logic                 regWrEn,
  output logic [REG_SEL_W-1:0] regWrSel,
  output logic [ADDR_W-1:0]    regWrData
);
  eaStrobe_t strobes;

  ea_gen_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .indexEn(indexEn), .memRdAck(memRdAck), .strobes(strobes),
    .validOut(valid), .memRdReq(memRdReq)
  );

  ea_gen_dp #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .REG_SEL_W(REG_SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeSel(modeSel),
    .indexEn(indexEn), .addrField(addrField), .regSel(regSel),
    .regRdData(regRdData), .pcNext(pcNext), .indexReg(indexReg),
    .memRdData(memRdData), .memRdAddr(memRdAddr), .effAddr(effAddr),
    .operandHit(operandHit), .operandVal(operandVal), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData)
  );

  // R12
  wr_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> valid);

  // R10
  read_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> $stable(memRdAddr));
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
  typedef struct packed {
    logic [2:0]  mode;
    logic        idx;
    logic [7:0]  field;
    logic [15:0] regv;
    logic [15:0] pc;
    logic [15:0] ixr;
    logic [15:0] expEa;
    logic        expHit;
    logic [15:0] expOp;
    logic        expWr;
    logic [15:0] expWd;
  } vec_t;

  // mode codes: 000 imm, 001 reg, 010 reg-indirect, 011 auto-inc, 100 auto-dec,
  // 101 direct, 110 indirect, 111 relative; idx=1 selects indexed
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 8'h5A, 16'h1111, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h005A, 1'b0, 16'h0000}, // R3
    '{3'b001, 1'b0, 8'h07, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h1234, 1'b0, 16'h0000}, // R4
    '{3'b010, 1'b0, 8'h00, 16'h4321, 16'h0000, 16'h0000, 16'h4321, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R5
    '{3'b011, 1'b0, 8'h00, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 16'h0000}, // R6
    '{3'b100, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'hFFFF}, // R7
    '{3'b101, 1'b0, 8'hC8, 16'h9999, 16'h0000, 16'h0000, 16'h00C8, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R2
    '{3'b111, 1'b0, 8'h18, 16'h0000, 16'h033A, 16'h0000, 16'h0352, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R8
    '{3'b111, 1'b0, 8'hF0, 16'h0000, 16'h0005, 16'h0000, 16'hFFF5, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R8
    '{3'b101, 1'b1, 8'h20, 16'h0000, 16'h0000, 16'hFFF0, 16'h0010, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R9
    '{3'b111, 1'b1, 8'h80, 16'h0000, 16'h7000, 16'h1000, 16'h1080, 1'b0, 16'h0000, 1'b0, 16'h0000}  // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  modeSel = '0;
  logic        indexEn = 1'b0;
  logic [7:0]  addrField = '0;
  logic [2:0]  regSel = '0;
  logic [15:0] regRdData = '0, pcNext = '0, indexReg = '0, memRdData = '0;
  logic        memRdAck = 1'b0;
  logic        memRdReq, valid, operandHit, regWrEn;
  logic [15:0] memRdAddr, effAddr, operandVal, regWrData;
  logic [2:0]  regWrSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel), .indexEn(indexEn),
    .addrField(addrField), .regSel(regSel), .regRdData(regRdData), .pcNext(pcNext),
    .indexReg(indexReg), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdAck(memRdAck), .memRdData(memRdData), .valid(valid), .effAddr(effAddr),
    .operandHit(operandHit), .operandVal(operandVal), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", {15'b0, valid}, 16'h0);
    chk("R1 memRdReq in reset", {15'b0, memRdReq}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid idle", {15'b0, valid}, 16'h0);
    chk("R1 regWrEn idle", {15'b0, regWrEn}, 16'h0);
    chk("R1 operandHit idle", {15'b0, operandHit}, 16'h0);
    chk("R1 effAddr idle", effAddr, 16'h0);

    for (int i = 0; i < NV; i++) begin
      modeSel = VECS[i].mode;  indexEn = VECS[i].idx;
      addrField = VECS[i].field; regRdData = VECS[i].regv;
      pcNext = VECS[i].pc; indexReg = VECS[i].ixr;
      regSel = 3'(i);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk($sformatf("R2 valid vec%0d", i), {15'b0, valid}, 16'h1);
      chk($sformatf("R2/R5/R8/R9 effAddr vec%0d", i), effAddr, VECS[i].expEa);
      chk($sformatf("R3/R4 operandHit vec%0d", i), {15'b0, operandHit}, {15'b0, VECS[i].expHit});
      if (VECS[i].expHit) chk($sformatf("R3/R4 operandVal vec%0d", i), operandVal, VECS[i].expOp);
      chk($sformatf("R12 regWrEn vec%0d", i), {15'b0, regWrEn}, {15'b0, VECS[i].expWr});
      if (VECS[i].expWr) begin
        chk($sformatf("R6/R7 regWrData vec%0d", i), regWrData, VECS[i].expWd);
        chk($sformatf("R6 regWrSel vec%0d", i), {13'b0, regWrSel}, 16'(i));
      end
      @(negedge clk);
      chk($sformatf("R2 valid drops vec%0d", i), {15'b0, valid}, 16'h0);
      chk($sformatf("R12 regWrEn drops vec%0d", i), {15'b0, regWrEn}, 16'h0);
    end

    // R10: indirect read with delayed acknowledge
    modeSel = 3'b110; indexEn = 1'b0; addrField = 8'h9C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 memRdReq raised", {15'b0, memRdReq}, 16'h1);
    chk("R10 memRdAddr", memRdAddr, 16'h009C);
    chk("R10 no early valid", {15'b0, valid}, 16'h0);
    // R11: start while read outstanding is ignored
    modeSel = 3'b101; addrField = 8'h33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 memRdAddr kept", memRdAddr, 16'h009C);
    chk("R11 no valid from ignored start", {15'b0, valid}, 16'h0);
    chk("R10 memRdReq held", {15'b0, memRdReq}, 16'h1);
    @(negedge clk);
    chk("R10 memRdReq still held", {15'b0, memRdReq}, 16'h1);
    memRdAck = 1'b1; memRdData = 16'hBEEF;
    @(negedge clk);
    memRdAck = 1'b0; memRdData = 16'h0000;
    chk("R10 valid after ack", {15'b0, valid}, 16'h1);
    chk("R10 effAddr from memory", effAddr, 16'hBEEF);
    chk("R10 memRdReq dropped", {15'b0, memRdReq}, 16'h0);
    chk("R10 operandHit low", {15'b0, operandHit}, 16'h0);
    @(negedge clk);
    chk("R11 single valid pulse", {15'b0, valid}, 16'h0);
    chk("R11 effAddr held", effAddr, 16'hBEEF);

    // R6: back-to-back auto-increment after indirect
    modeSel = 3'b011; regRdData = 16'h00FF; regSel = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 effAddr", effAddr, 16'h00FF);
    chk("R6 regWrData", regWrData, 16'h0100);
    chk("R6 regWrSel", {13'b0, regWrSel}, 16'h0005);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule